// File: doc/BRIEF.md
# Flip-Bit Three-Phase Write Controller

This controller sits in front of a word-organised array of non-volatile cells in which setting a cell to one needs a longer programming pulse than clearing it to zero. Every stored word carries one extra flag cell. When the flag is set, the data cells hold the bitwise inverse of the word that the user wrote. A write request is accepted over a valid/ready handshake. The controller reads the old cells in a single compare cycle and picks whichever form, true or inverted, changes fewer cells. The flag cell is counted in that total.

The write then proceeds in two timed programming phases. In the first phase, per-cell clear enables are driven for the cells that must fall from one to zero. In the second phase, per-cell set enables are driven for the cells that must rise from zero to one. A phase with no cell to program is skipped. The cell array is modelled inside the block as a register array, and each cell takes its new value when its phase ends. A combinational read port decodes the stored word through its flag, so callers always see the data they wrote.

Top module: `flipwrite_ctrl`

## Requirements
- R1: After reset every word reads back as zero with flag zero, wr_ready is high, done is low and both enable vectors are zero.
- R2: A request is taken on a clock edge where wr_valid and wr_ready are both high. From the edge that accepts it, wr_ready stays low until the write completes. done is a one-cycle pulse in the first cycle in which wr_ready is high again.
- R3: Counted from the accepting edge, wr_ready is low for 1 + T_ZERO·z + T_ONE·o cycles. Here z is 1 if any cell must be cleared and o is 1 if any cell must be set; each is 0 otherwise.
- R4: Right after the compare cycle, prog0_en carries the clear mask for exactly T_ZERO consecutive cycles. The clear mask holds the cells that are 1 now and 0 in the target. Bit DATA_W is the flag cell and bits DATA_W-1:0 are the data cells. prog0_en is zero at all other times.
- R5: After the clear phase, or right after the compare cycle if the clear phase is skipped, prog1_en carries the set mask for exactly T_ONE cycles. The set mask holds the cells that are 0 now and 1 in the target, with the same bit layout as R4. prog1_en is zero at all other times.
- R6: The stored form is the one that changes fewer cells, so a write never changes more than half of the DATA_W+1 cells.
- R7: If both forms change the same number of cells, the flag value already stored is kept.
- R8: rd_data equals the data cells of word rd_addr, XORed with that word's flag. After a completed write it returns the written word.
- R9: A write that changes no cell drives no enable and completes one cycle after acceptance.
- R10: prog0_en and prog1_en are never nonzero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Controller idle, able to accept a request |
| wr_addr | input | $clog2(DEPTH) | Word address of the write |
| wr_data | input | DATA_W | Word to write |
| done | output | 1 | One-cycle pulse when a write completes |
| prog0_en | output | DATA_W+1 | Per-cell clear enables, flag in the top bit |
| prog1_en | output | DATA_W+1 | Per-cell set enables, flag in the top bit |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | DATA_W | Decoded read data |

## Verification
A wrong inversion choice or a corrupted flag cell shows at the ports in two ways. The enable masks of that same write come out with the wrong bits or the wrong number of bits, and a read of the word after done returns damaged data. A phase counter that is off by one, or a phase that is not skipped when it should be, changes the number of cycles that wr_ready stays low. That error can be seen when done arrives. Because each later write computes its masks from the stored cells, a bad cell also shows up in the enables of the next write to that address.

// File: rtl/flipwrite_ctrl.sv
module flipwrite_ctrl #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int T_ZERO = 2,
  parameter int T_ONE  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     done,
  output logic [DATA_W:0]          prog0_en,
  output logic [DATA_W:0]          prog1_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int W  = DATA_W + 1;
  localparam int AW = $clog2(DEPTH);
  localparam int TM = (T_ZERO > T_ONE) ? T_ZERO : T_ONE;
  localparam int CW = $clog2(TM + 1);
  localparam int NW = $clog2(W + 1);

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_ZERO, S_ONE} state_t;

  state_t          state;
  logic [W-1:0]    cells [DEPTH];
  logic [AW-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic [W-1:0]    zmask_q, omask_q;
  logic [CW-1:0]   cnt;

  logic [W-1:0]    old_w, tgt, zmask, omask;
  logic [NW-1:0]   cost_true, cost_inv;
  logic            pick_inv;

  assign old_w     = cells[addr_q];
  assign cost_true = NW'($countones(old_w[DATA_W-1:0] ^ data_q)) + NW'(old_w[DATA_W]);
  assign cost_inv  = NW'(W) - cost_true;
  assign pick_inv  = (cost_true > cost_inv) || ((cost_true == cost_inv) && old_w[DATA_W]);
  assign tgt       = {pick_inv, data_q ^ {DATA_W{pick_inv}}};
  assign zmask     = old_w & ~tgt;
  assign omask     = ~old_w & tgt;

  assign wr_ready = (state == S_IDLE);
  assign prog0_en = (state == S_ZERO) ? zmask_q : '0;
  assign prog1_en = (state == S_ONE)  ? omask_q : '0;
  assign rd_data  = cells[rd_addr][DATA_W-1:0] ^ {DATA_W{cells[rd_addr][DATA_W]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      zmask_q <= '0;
      omask_q <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (wr_valid) begin
          addr_q <= wr_addr;
          data_q <= wr_data;
          state  <= S_CMP;
        end
        S_CMP: begin
          zmask_q <= zmask;
          omask_q <= omask;
          cnt     <= '0;
          if (|zmask)      state <= S_ZERO;
          else if (|omask) state <= S_ONE;
          else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_ZERO: begin
          if (cnt == CW'(T_ZERO - 1)) begin
            cells[addr_q] <= cells[addr_q] & ~zmask_q;
            cnt <= '0;
            if (|omask_q) state <= S_ONE;
            else begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_ONE: begin
          if (cnt == CW'(T_ONE - 1)) begin
            cells[addr_q] <= cells[addr_q] | omask_q;
            cnt   <= '0;
            state <= S_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_ready);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_clear_only_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog0_en & ~cells[addr_q]) == '0);
  assert_set_only_zeros_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog1_en & cells[addr_q]) == '0);
  assert_few_changes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(zmask_q | omask_q) <= W / 2);
  assert_decodes_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cells[addr_q][DATA_W-1:0] ^ {DATA_W{cells[addr_q][DATA_W]}}) == data_q);
  assert_phases_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|prog0_en) && (|prog1_en)));
endmodule

// File: tb/test_flipwrite_ctrl.sv
module test_flipwrite_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 7;
  localparam int W  = DW + 1;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int TZ = 2;
  localparam int TO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready, done;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [W-1:0]  prog0_en, prog1_en;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [DEPTH];
  logic [W-1:0] seen_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  flipwrite_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .T_ZERO(TZ), .T_ONE(TO)) i_flipwrite_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .prog0_en(prog0_en), .prog1_en(prog1_en), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [W-1:0] target(input logic [W-1:0] old, input logic [DW-1:0] d);
    int ct, ci;
    logic f;
    ct = 0;
    for (int i = 0; i < DW; i++) if (old[i] != d[i]) ct++;
    if (old[DW]) ct++;
    ci = W - ct;
    f = (ct > ci) ? 1'b1 : (ct < ci) ? 1'b0 : old[DW];
    return {f, d ^ {DW{f}}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [W-1:0] old, tg, z, o, e0, e1;
    int tz, to, len;
    bit bad0, bad1, badh, ovl;
    logic [W-1:0] a0, a1, x0, x1;
    old = model[a];
    tg = target(old, d);
    z = old & ~tg;
    o = ~old & tg;
    tz = (z != 0) ? TZ : 0;
    to = (o != 0) ? TO : 0;
    len = 1 + tz + to;
    bad0 = 0; bad1 = 0; badh = 0; ovl = 0; seen_mask = '0;
    a0 = '0; a1 = '0; x0 = '0; x1 = '0;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    for (int k = 1; k <= len + 1; k++) begin
      @(negedge clk);
      e0 = (k >= 2 && k < 2 + tz) ? z : '0;
      e1 = (k >= 2 + tz && k < 2 + tz + to) ? o : '0;
      if (prog0_en != e0 && !bad0) begin bad0 = 1; a0 = prog0_en; x0 = e0; end
      if (prog1_en != e1 && !bad1) begin bad1 = 1; a1 = prog1_en; x1 = e1; end
      if (wr_ready != (k == len + 1) || done != (k == len + 1)) badh = 1;
      if (prog0_en != 0 && prog1_en != 0) ovl = 1;
      seen_mask = seen_mask | prog0_en | prog1_en;
    end
    check(!badh, "R2/R3 ready-done timing", {wr_ready, done}, 2'b11);
    check(!bad0, "R4 clear enables", a0, x0);
    check(!bad1, "R5 set enables", a1, x1);
    check(!ovl, "R10 phases overlap", 1, 0);
    check($countones(seen_mask) <= W / 2, "R6 change count", $countones(seen_mask), W / 2);
    model[a] = tg;
    rd_addr = a;
    #1;
    check(rd_data == d, "R8 read back", rd_data, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_ready && !done && prog0_en == 0 && prog1_en == 0, "R1 idle outputs",
          {wr_ready, done, prog0_en, prog1_en}, {1'b1, 1'b0, 16'h0});
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      #1 check(rd_data == 0, "R1 reset contents", rd_data, 0);
    end
    @(negedge clk);
    // all ones into a fresh word: inverted form, only the flag is set
    do_write(3'd1, 7'h7F);
    check(seen_mask == 8'h80, "R6 inverted form chosen", seen_mask, 8'h80);
    // same data again: nothing to program
    do_write(3'd1, 7'h7F);
    check(seen_mask == 0, "R9 unchanged write", seen_mask, 0);
    // tie with flag 0 stored: flag stays 0
    do_write(3'd2, 7'h0F);
    check(seen_mask[DW] == 1'b0, "R7 tie keeps flag 0", seen_mask, 8'h0F);
    // tie with flag 1 stored (word 1 holds cells 0x80): three data changes plus flag cost
    do_write(3'd1, 7'h70);
    check(seen_mask[DW] == 1'b0, "R7 tie keeps flag 1", seen_mask, 8'h0F);
    for (int n = 0; n < 250; n++)
      do_write(AW'($urandom % DEPTH), DW'($urandom));
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = AW'(i);
      #1 check(rd_data == (model[i][DW-1:0] ^ {DW{model[i][DW]}}), "R8 final contents",
               rd_data, model[i][DW-1:0] ^ {DW{model[i][DW]}});
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule